// File: doc/BRIEF.md
# Slot Power Mode Controller

This block decides how three slot power switches (main, secondary and auxiliary) are driven for a removable card slot. It samples digital status lines: an auxiliary-supply-good flag, main and secondary supply-good flags, active-low shutdown and standby requests, two active-low card-detect lines, and one overcurrent flag per switch. For each rail it issues a 2-bit command: float (switch open, no discharge), connect, or discharge to ground. It also publishes a mode code for a downstream reset sequencer and an active-low, deglitched overcurrent status.

Every input passes a two-stage synchronizer. A single state machine then picks the mode from the synchronized inputs. The order in which a standby request and a card insertion arrive changes the result, and the machine records that order. The rail commands are decoded from the state alone, so they change only on a state transition.

States and the transitions between them are evaluated in fixed priority. Loss of the auxiliary supply moves any state to `MD_NOAUX`. Otherwise a shutdown request moves any state to `MD_SHUTDOWN`. Otherwise a missing card moves any state to `MD_NOCARD`. With a card present and both requests released, the machine goes to `MD_ACTIVE` when both main and secondary supplies are good and to `MD_AUX_ONLY` when either is not. With standby held and a card present, the machine goes to `MD_STANDBY` if it was in `MD_ACTIVE`, `MD_AUX_ONLY` or `MD_STANDBY`. From `MD_NOAUX`, `MD_SHUTDOWN`, `MD_NOCARD` or `MD_STBY_OFF` it goes to `MD_STBY_OFF` instead.

Top module: `slot_pwr_ctrl`

## Requirements
- R1: A card is present when either card-detect line is low. It is absent only when both lines are high.
- R2: While the auxiliary supply is not good, the mode is `MD_NOAUX` (code 0) and all three rail commands are float (2'b00).
- R3: With the auxiliary supply good and the shutdown request low, the mode is `MD_SHUTDOWN` (code 1) and all three rails are discharge (2'b10). This applies whatever the state of the standby request, the card and the other supplies.
- R4: With the auxiliary supply good, shutdown released and no card, the mode is `MD_NOCARD` (code 2) and all three rails are discharge.
- R5: A standby request raised while the machine is powering a card (`MD_ACTIVE` or `MD_AUX_ONLY`) gives `MD_STANDBY` (code 4). In that mode auxiliary is connected (2'b01) and main and secondary float.
- R6: A standby request that is already low when the card appears, or when shutdown or auxiliary loss ends, gives `MD_STBY_OFF` (code 3) with all rails floating. This mode holds until standby is released or the card is removed; a supply coming good does not end it.
- R7: With a card present and both requests released, a main or secondary supply that is not good gives `MD_AUX_ONLY` (code 5): auxiliary connected, main and secondary floating.
- R8: With all three supplies good, both requests released and a card present, the mode is `MD_ACTIVE` (code 6) and all three rails are connected.
- R9: No rail command is ever 2'b11.
- R10: The overcurrent status goes low once any overcurrent flag has been seen for `DEGLITCH_CYC` consecutive synchronized cycles. It goes high again once all flags have been clear for the same count. Shorter excursions in either direction leave it unchanged.
- R11: A change on any input reaches the mode and rail outputs on the third rising clock edge after it, following two synchronizer stages and the state register.
- R12: During and directly after reset the mode is `MD_NOAUX`, all rails float and the overcurrent status is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| aux_ok_i | input | 1 | Auxiliary supply good |
| main_ok_i | input | 1 | Main supply good |
| sec_ok_i | input | 1 | Secondary supply good |
| shdn_req_n_i | input | 1 | Shutdown request, active low |
| stby_req_n_i | input | 1 | Standby request, active low |
| card_a_n_i | input | 1 | First card-detect line, active low |
| card_b_n_i | input | 1 | Second card-detect line, active low |
| oc_flag_i | input | 3 | Overcurrent flags: bit 0 main, bit 1 secondary, bit 2 auxiliary |
| main_cmd_o | output | 2 | Main rail command (00 float, 01 connect, 10 discharge) |
| sec_cmd_o | output | 2 | Secondary rail command |
| aux_cmd_o | output | 2 | Auxiliary rail command |
| mode_o | output | 3 | Mode code for the reset sequencer |
| oc_n_o | output | 1 | Deglitched overcurrent status, active low |

## Verification
The sharpest corner case is the order of standby and insertion. Suppose a design dropped the history and derived the mode from the present inputs alone. It would then connect auxiliary when standby was held before the card arrived, or float everything when standby arrived after it. The bench inserts and removes cards while standby is held, and flips the supply flags inside `MD_STBY_OFF`, so that a latch that clears on the wrong event shows up as a mode mismatch. It also tests priority by holding shutdown together with standby and with card removal, where a wrong ordering would float rails that must discharge. For the overcurrent filter it sends excursions shorter than the window in both directions; a filter that lacks a counter reset, or that has an off-by-one limit, would move the status early.

// File: rtl/slot_pwr_pkg.sv
package slot_pwr_pkg;

    typedef enum logic [1:0] {
        RAIL_FLOAT = 2'b00,
        RAIL_ON    = 2'b01,
        RAIL_GND   = 2'b10
    } rail_cmd_e;

    typedef enum logic [2:0] {
        MD_NOAUX    = 3'd0,
        MD_SHUTDOWN = 3'd1,
        MD_NOCARD   = 3'd2,
        MD_STBY_OFF = 3'd3,
        MD_STANDBY  = 3'd4,
        MD_AUX_ONLY = 3'd5,
        MD_ACTIVE   = 3'd6
    } mode_e;

    localparam int NUM_RAILS = 3;

    // Synchronizer bus layout
    localparam int IDX_AUX   = 0;
    localparam int IDX_MAIN  = 1;
    localparam int IDX_SEC   = 2;
    localparam int IDX_SHDN  = 3;
    localparam int IDX_STBY  = 4;
    localparam int IDX_CARDA = 5;
    localparam int IDX_CARDB = 6;
    localparam int IDX_OC    = 7;
    localparam int SYNC_W    = IDX_OC + NUM_RAILS;

endpackage

// File: rtl/slot_pwr_sync.sv
module slot_pwr_sync #(
    parameter int              W       = 8,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] pipe [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pipe[s] <= RST_VAL;
                    else        pipe[s] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pipe[s] <= RST_VAL;
                    else        pipe[s] <= pipe[s-1];
                end
            end
        end
    endgenerate

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/slot_oc_filter.sv
module slot_oc_filter #(
    parameter int unsigned DEGLITCH_CYC = 1000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic oc_any,
    output logic oc_n
);

    localparam int CW = (DEGLITCH_CYC > 1) ? $clog2(DEGLITCH_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(DEGLITCH_CYC - 1);

    logic          held;
    logic [CW-1:0] run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held <= 1'b0;
            run  <= '0;
        end else if (oc_any == held) begin
            run <= '0;
        end else if (run == LAST) begin
            held <= oc_any;
            run  <= '0;
        end else begin
            run <= run + 1'b1;
        end
    end

    assign oc_n = ~held;

endmodule

// File: rtl/slot_pwr_fsm.sv
module slot_pwr_fsm
    import slot_pwr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      aux_ok,
    input  logic      main_ok,
    input  logic      sec_ok,
    input  logic      shdn_n,
    input  logic      stby_n,
    input  logic      card_in,
    output mode_e     mode,
    output rail_cmd_e main_cmd,
    output rail_cmd_e sec_cmd,
    output rail_cmd_e aux_cmd
);

    mode_e state, nxt;
    logic  rails_ok;
    mode_e run_target;

    assign rails_ok   = main_ok & sec_ok;
    assign run_target = rails_ok ? MD_ACTIVE : MD_AUX_ONLY;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= MD_NOAUX;
        else        state <= nxt;
    end

    // Transitions
    always_comb begin
        nxt = state;
        if (!aux_ok) begin
            nxt = MD_NOAUX;
        end else if (!shdn_n) begin
            nxt = MD_SHUTDOWN;
        end else if (!card_in) begin
            nxt = MD_NOCARD;
        end else begin
            unique case (state)
                MD_NOAUX, MD_SHUTDOWN, MD_NOCARD, MD_STBY_OFF:
                    nxt = stby_n ? run_target : MD_STBY_OFF;
                MD_STANDBY, MD_AUX_ONLY, MD_ACTIVE:
                    nxt = stby_n ? run_target : MD_STANDBY;
                default:
                    nxt = MD_NOAUX;
            endcase
        end
    end

    // Outputs
    always_comb begin
        main_cmd = RAIL_FLOAT;
        sec_cmd  = RAIL_FLOAT;
        aux_cmd  = RAIL_FLOAT;
        unique case (state)
            MD_SHUTDOWN, MD_NOCARD: begin
                main_cmd = RAIL_GND;
                sec_cmd  = RAIL_GND;
                aux_cmd  = RAIL_GND;
            end
            MD_STANDBY, MD_AUX_ONLY: begin
                aux_cmd = RAIL_ON;
            end
            MD_ACTIVE: begin
                main_cmd = RAIL_ON;
                sec_cmd  = RAIL_ON;
                aux_cmd  = RAIL_ON;
            end
            default: begin
                main_cmd = RAIL_FLOAT;
                sec_cmd  = RAIL_FLOAT;
                aux_cmd  = RAIL_FLOAT;
            end
        endcase
    end

    assign mode = state;

endmodule

// File: rtl/slot_pwr_ctrl.sv
module slot_pwr_ctrl
    import slot_pwr_pkg::*;
#(
    parameter int unsigned DEGLITCH_CYC = 1000000,
    parameter int          SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       aux_ok_i,
    input  logic       main_ok_i,
    input  logic       sec_ok_i,
    input  logic       shdn_req_n_i,
    input  logic       stby_req_n_i,
    input  logic       card_a_n_i,
    input  logic       card_b_n_i,
    input  logic [2:0] oc_flag_i,
    output logic [1:0] main_cmd_o,
    output logic [1:0] sec_cmd_o,
    output logic [1:0] aux_cmd_o,
    output logic [2:0] mode_o,
    output logic       oc_n_o
);

    // Idle values: supplies bad, requests and card lines released, no overcurrent
    localparam logic [SYNC_W-1:0] SYNC_IDLE =
        (SYNC_W'(1) << IDX_SHDN) | (SYNC_W'(1) << IDX_STBY) |
        (SYNC_W'(1) << IDX_CARDA) | (SYNC_W'(1) << IDX_CARDB);

    logic [SYNC_W-1:0] raw_bus, syn_bus;
    logic              s_aux_ok, s_main_ok, s_sec_ok, s_shdn_n, s_stby_n;
    logic              s_card_in, s_oc_any;
    mode_e             mode;
    rail_cmd_e         main_cmd, sec_cmd, aux_cmd;

    assign raw_bus = {oc_flag_i, card_b_n_i, card_a_n_i, stby_req_n_i,
                      shdn_req_n_i, sec_ok_i, main_ok_i, aux_ok_i};

    slot_pwr_sync #(
        .W       (SYNC_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_IDLE)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_bus),
        .q     (syn_bus)
    );

    assign s_aux_ok  = syn_bus[IDX_AUX];
    assign s_main_ok = syn_bus[IDX_MAIN];
    assign s_sec_ok  = syn_bus[IDX_SEC];
    assign s_shdn_n  = syn_bus[IDX_SHDN];
    assign s_stby_n  = syn_bus[IDX_STBY];
    assign s_card_in = ~(syn_bus[IDX_CARDA] & syn_bus[IDX_CARDB]);
    assign s_oc_any  = |syn_bus[IDX_OC +: NUM_RAILS];

    slot_pwr_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .aux_ok   (s_aux_ok),
        .main_ok  (s_main_ok),
        .sec_ok   (s_sec_ok),
        .shdn_n   (s_shdn_n),
        .stby_n   (s_stby_n),
        .card_in  (s_card_in),
        .mode     (mode),
        .main_cmd (main_cmd),
        .sec_cmd  (sec_cmd),
        .aux_cmd  (aux_cmd)
    );

    slot_oc_filter #(
        .DEGLITCH_CYC (DEGLITCH_CYC)
    ) u_ocf (
        .clk    (clk),
        .rst_n  (rst_n),
        .oc_any (s_oc_any),
        .oc_n   (oc_n_o)
    );

    assign main_cmd_o = main_cmd;
    assign sec_cmd_o  = sec_cmd;
    assign aux_cmd_o  = aux_cmd;
    assign mode_o     = mode;

endmodule

// File: rtl/slot_pwr_ctrl_chk.sv
module slot_pwr_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       aux_s,
    input logic       main_s,
    input logic       sec_s,
    input logic       shdn_s,
    input logic       stby_s,
    input logic       oc_any_s,
    input logic [1:0] main_cmd,
    input logic [1:0] sec_cmd,
    input logic [1:0] aux_cmd,
    input logic [2:0] mode,
    input logic       oc_n
);

    // R9
    cmd_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (main_cmd != 2'b11) && (sec_cmd != 2'b11) && (aux_cmd != 2'b11));

    // R2
    noaux_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !aux_s |=> (mode == 3'd0) && (main_cmd == 2'b00) && (sec_cmd == 2'b00) && (aux_cmd == 2'b00));

    // R3
    shdn_discharge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (aux_s && !shdn_s) |=> (main_cmd == 2'b10) && (sec_cmd == 2'b10) && (aux_cmd == 2'b10));

    // R6
    stby_off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd3) |-> !$past(stby_s));

    // R8
    active_needs_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd6) |-> $past(aux_s && main_s && sec_s && shdn_s && stby_s));

    // R10
    oc_assert_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(oc_n) |-> $past(oc_any_s));

    // R10
    oc_release_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oc_n) |-> !$past(oc_any_s));

endmodule

bind slot_pwr_ctrl slot_pwr_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .aux_s    (s_aux_ok),
    .main_s   (s_main_ok),
    .sec_s    (s_sec_ok),
    .shdn_s   (s_shdn_n),
    .stby_s   (s_stby_n),
    .oc_any_s (s_oc_any),
    .main_cmd (main_cmd_o),
    .sec_cmd  (sec_cmd_o),
    .aux_cmd  (aux_cmd_o),
    .mode     (mode_o),
    .oc_n     (oc_n_o)
);

// File: tb/test_slot_pwr_ctrl.sv
`timescale 1ns/1ps
module test_slot_pwr_ctrl;

    localparam int DG = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       aux_ok = 0, main_ok = 0, sec_ok = 0;
    logic       shdn_n = 1, stby_n = 1, cpa_n = 1, cpb_n = 1;
    logic [2:0] oc = 3'b000;
    logic [1:0] main_cmd, sec_cmd, aux_cmd;
    logic [2:0] mode;
    logic       oc_n;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    slot_pwr_ctrl #(.DEGLITCH_CYC(DG)) i_slot_pwr_ctrl (
        .clk (clk), .rst_n (rst_n),
        .aux_ok_i (aux_ok), .main_ok_i (main_ok), .sec_ok_i (sec_ok),
        .shdn_req_n_i (shdn_n), .stby_req_n_i (stby_n),
        .card_a_n_i (cpa_n), .card_b_n_i (cpb_n), .oc_flag_i (oc),
        .main_cmd_o (main_cmd), .sec_cmd_o (sec_cmd), .aux_cmd_o (aux_cmd),
        .mode_o (mode), .oc_n_o (oc_n)
    );

    // ---------------- reference model ----------------
    // input snapshot: {aux, main, sec, shdn_n, stby_n, card, oc_any}
    logic [6:0] q1, q2;
    int         m_mode;
    bit         m_oc;
    int         m_run;

    function automatic logic [6:0] snap();
        return {aux_ok, main_ok, sec_ok, shdn_n, stby_n, !(cpa_n && cpb_n), |oc};
    endfunction

    function automatic int next_mode(int cur, logic [6:0] s);
        bit powered;
        powered = (cur == 4) || (cur == 5) || (cur == 6);
        if (!s[6])      return 0;
        if (!s[3])      return 1;
        if (!s[1])      return 2;
        if (!s[2])      return powered ? 4 : 3;
        if (s[5] && s[4]) return 6;
        return 5;
    endfunction

    function automatic logic [5:0] rails_for(int md);
        case (md)
            1, 2:    return 6'b10_10_10;
            4, 5:    return 6'b00_00_01;
            6:       return 6'b01_01_01;
            default: return 6'b00_00_00;
        endcase
    endfunction

    function automatic string tag_for(int md);
        case (md)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            3: return "R6";
            4: return "R5";
            5: return "R7";
            default: return "R8";
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            q1 = 7'b0001110; q2 = 7'b0001110;
            m_mode = 0; m_oc = 0; m_run = 0;
        end else begin
            m_mode = next_mode(m_mode, q2);
            if (q2[0] != m_oc) begin
                m_run++;
                if (m_run == DG) begin m_oc = q2[0]; m_run = 0; end
            end else begin
                m_run = 0;
            end
            q2 = q1;
            q1 = snap();
        end
    end

    task automatic check(string tag, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Per-cycle comparison; mode timing also covers R11
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            logic [5:0] r;
            r = rails_for(m_mode);
            check("R11", "mode", mode, m_mode);
            check(tag_for(m_mode), "rails", {main_cmd, sec_cmd, aux_cmd}, r);
            check("R9", "no 11 code",
                  (main_cmd == 2'b11) || (sec_cmd == 2'b11) || (aux_cmd == 2'b11), 0);
            check("R10", "oc_n", oc_n, !m_oc);
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_mode(string tag, int code);
        check(tag, "directed mode", mode, code);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        step(4);
        rst_n = 1'b1;
        step(1);
        // R12 reset state
        check("R12", "reset mode", mode, 0);
        check("R12", "reset rails", {main_cmd, sec_cmd, aux_cmd}, 0);
        check("R12", "reset oc_n", oc_n, 1);

        aux_ok = 1; step(5); expect_mode("R4", 2);
        cpa_n = 0; main_ok = 1; sec_ok = 1; step(5); expect_mode("R1", 6);
        cpa_n = 1; cpb_n = 0; step(5); expect_mode("R1", 6);
        stby_n = 0; step(5); expect_mode("R5", 4);
        stby_n = 1; step(5); expect_mode("R8", 6);
        main_ok = 0; step(5); expect_mode("R7", 5);
        main_ok = 1; step(5); expect_mode("R8", 6);
        sec_ok = 0; step(5); expect_mode("R7", 5);
        stby_n = 0; step(5); expect_mode("R5", 4);
        stby_n = 1; sec_ok = 1; step(5); expect_mode("R8", 6);
        shdn_n = 0; step(5); expect_mode("R3", 1);
        stby_n = 0; step(5); expect_mode("R3", 1);
        cpb_n = 1; step(5); expect_mode("R3", 1);
        shdn_n = 1; step(5); expect_mode("R4", 2);
        cpa_n = 0; step(5); expect_mode("R6", 3);
        main_ok = 0; step(3); main_ok = 1; step(5); expect_mode("R6", 3);
        stby_n = 1; step(5); expect_mode("R8", 6);
        stby_n = 0; step(5); expect_mode("R5", 4);
        cpa_n = 1; step(5); expect_mode("R4", 2);
        cpb_n = 0; step(5); expect_mode("R6", 3);
        stby_n = 1; step(5); expect_mode("R8", 6);
        aux_ok = 0; step(5); expect_mode("R2", 0);
        check("R2", "float rails", {main_cmd, sec_cmd, aux_cmd}, 0);
        aux_ok = 1; step(5); expect_mode("R8", 6);

        // R10 overcurrent filter
        oc = 3'b010; step(DG - 4); oc = 3'b000; step(14);
        check("R10", "short pulse ignored", oc_n, 1);
        oc = 3'b001; step(DG + 6);
        check("R10", "long pulse asserts", oc_n, 0);
        oc = 3'b000; step(DG - 4); oc = 3'b100; step(3);
        check("R10", "short gap ignored", oc_n, 0);
        oc = 3'b000; step(DG + 6);
        check("R10", "long clear releases", oc_n, 1);

        step(2);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule